// File: doc/BRIEF.md
# Multiframe Alignment Receiver for a 789-bit Frame Stream

This block takes a serial second-level hierarchy stream one bit at a time and locks onto its frame and multiframe boundaries. Each frame is 789 bits long, and four frames form a multiframe. The overhead sits in the last five bits of each frame. A nine-bit alignment word is spread across the overhead of frames 1 and 2. In frame 1 the word takes four bits, and the bit after them is skipped. In frame 2 the word takes all five overhead bits. The receiver finds this word by bit slipping. It reports the position of the next bit and an in-sync flag. It also extracts the data-link bits and the remote alarm bit.

The input side is a serial bit qualified by `in_valid`. It has no back-pressure and no ready signal: every cycle with `in_valid` high consumes exactly one line bit, and cycles with `in_valid` low are ignored. The frame length and the confirm and loss counts are parameters. The position of the alignment word, the data-link bits and the alarm bit is fixed relative to the end of each frame.

Top module: `mfa_align_rx`

## Requirements
- R1: After reset, `in_sync`, `alarm`, `link_valid` and `link_bit` are 0, and `bit_pos` and `frame_num` are 0.
- R2: A cycle with `in_valid` low changes neither `bit_pos` nor `frame_num`.
- R3: The alignment word is 1,1,0,0 on bits L-4..L-1 of frame 1, followed by 1,0,1,0,0 on bits L-4..L of frame 2. Bits are numbered 1..L. `in_sync` rises after two consecutive complete multiframes in which all nine alignment bits matched, and no earlier. It rises on the edge that consumes the last bit of frame 4, and then `bit_pos` = 0 and `frame_num` = 0.
- R4: `bit_pos` (0..L-1) and `frame_num` (0..3, encoding frames 1..4) give the position that the next accepted bit will occupy. While in sync they follow the line exactly, wrapping from L-1 to 0 and from 3 to 0.
- R5: While in sync, consuming the last bit of frame 1 or frame 3 raises `link_valid` for one cycle, and `link_bit` carries that bit.
- R6: While in sync, consuming bit L-1 of frame 3 loads `alarm` with that bit (1 means alarm). Out of sync, `alarm` holds its value.
- R7: While in sync, `in_sync` falls at the end of the third consecutive multiframe that contains an alignment error. One or two errored multiframes followed by a clean one do not drop sync.
- R8: Out of sync, an alignment mismatch holds the position counter for that bit. This makes the block lock onto a stream that starts at any offset.
- R9: `link_valid` stays low while the block is out of sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Line bit present this cycle |
| in_bit | input | 1 | Serial line bit |
| bit_pos | output | $clog2(FRAME_LEN) | Bit index of the next bit within its frame (0-based) |
| frame_num | output | 2 | Frame index of the next bit in the multiframe (0 = frame 1) |
| in_sync | output | 1 | Frame and multiframe alignment held |
| link_valid | output | 1 | One-cycle strobe: `link_bit` is new |
| link_bit | output | 1 | Last extracted data-link bit |
| alarm | output | 1 | Last remote alarm bit received in sync |

## Verification
Alignment error counting and overhead extraction run together inside the same multiframe. While the block is still in sync during its first and second errored multiframes, the alarm and data-link bits must still be taken from the line. The bench provokes this by corrupting one alignment bit of frame 2 in several multiframes in a row while giving the alarm bit a fresh random value each multiframe. Each captured alarm and link bit is checked against what was sent. After sync is lost, the bench checks that a changed alarm bit leaves `alarm` at its last in-sync value.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
  // Nine-bit alignment word: MSB first, bits [8:5] in frame 1, bits [4:0] in frame 2
  localparam logic [8:0] ALIGN_WORD = 9'b110010100;
  localparam int unsigned MF_FRAMES = 4;
  localparam int unsigned FRM_W = 2;
  localparam int unsigned OH_BITS = 5;
endpackage

// File: rtl/mfa_pos_counter.sv
module mfa_pos_counter #(
  parameter int unsigned FRAME_LEN = 789,
  parameter int unsigned POS_W = $clog2(FRAME_LEN),
  parameter int unsigned FRM_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [POS_W-1:0] bit_pos,
  output logic [FRM_W-1:0] frame_num,
  output logic             mf_last
);
  localparam logic [POS_W-1:0] LAST_BIT = POS_W'(FRAME_LEN - 1);

  logic frame_last;
  assign frame_last = (bit_pos == LAST_BIT);
  assign mf_last    = frame_last && (frame_num == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_pos   <= '0;
      frame_num <= '0;
    end else if (adv) begin
      if (frame_last) begin
        bit_pos   <= '0;
        frame_num <= frame_num + 1'b1;
      end else begin
        bit_pos <= bit_pos + 1'b1;
      end
    end
  end

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_pos <= LAST_BIT); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(bit_pos) && $stable(frame_num)); // R2
endmodule

// File: rtl/mfa_slot_decode.sv
module mfa_slot_decode
  import mfa_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 789,
  parameter int unsigned POS_W = $clog2(FRAME_LEN)
) (
  input  logic [POS_W-1:0] bit_pos,
  input  logic [FRM_W-1:0] frame_num,
  output logic             align_slot,
  output logic             align_exp,
  output logic             link_slot,
  output logic             alarm_slot
);
  localparam logic [POS_W-1:0] OH_START = POS_W'(FRAME_LEN - OH_BITS);
  localparam logic [POS_W-1:0] LAST_BIT = POS_W'(FRAME_LEN - 1);
  localparam logic [POS_W-1:0] PEN_BIT  = POS_W'(FRAME_LEN - 2);

  logic             in_oh;
  logic [POS_W-1:0] off;
  logic [3:0]       idx;
  logic [15:0]      word;

  assign word  = {7'b0, ALIGN_WORD};
  assign in_oh = (bit_pos >= OH_START);
  assign off   = bit_pos - OH_START;

  always_comb begin
    align_slot = 1'b0;
    idx        = 4'd0;
    if (frame_num == 2'd0) begin
      align_slot = in_oh && (bit_pos != LAST_BIT);
      idx        = 4'd8 - off[3:0];
    end else if (frame_num == 2'd1) begin
      align_slot = in_oh;
      idx        = 4'd4 - off[3:0];
    end
    align_exp = align_slot & word[idx];
  end

  assign link_slot  = (frame_num == 2'd0 || frame_num == 2'd2) && (bit_pos == LAST_BIT);
  assign alarm_slot = (frame_num == 2'd2) && (bit_pos == PEN_BIT);
endmodule

// File: rtl/mfa_sync_ctrl.sv
module mfa_sync_ctrl #(
  parameter int unsigned CONFIRM_MF = 2,
  parameter int unsigned LOSS_MF = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic mismatch,
  input  logic mf_last,
  output logic locked,
  output logic slip
);
  localparam int unsigned HIT_W  = $clog2(CONFIRM_MF + 1);
  localparam int unsigned MISS_W = $clog2(LOSS_MF + 1);

  logic              mf_ok;
  logic [HIT_W-1:0]  hits;
  logic [MISS_W-1:0] misses;

  assign slip = in_valid && mismatch && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      mf_ok  <= 1'b1;
      hits   <= '0;
      misses <= '0;
    end else if (in_valid) begin
      if (mismatch) begin
        mf_ok <= 1'b0;
        if (!locked) hits <= '0;
      end
      if (mf_last) begin
        mf_ok <= 1'b1;
        if (!locked) begin
          if (!mf_ok) hits <= '0;
          else if (hits == HIT_W'(CONFIRM_MF - 1)) begin
            locked <= 1'b1;
            hits   <= '0;
            misses <= '0;
          end else hits <= hits + 1'b1;
        end else begin
          if (mf_ok) misses <= '0;
          else if (misses == MISS_W'(LOSS_MF - 1)) begin
            locked <= 1'b0;
            misses <= '0;
            hits   <= '0;
          end else misses <= misses + 1'b1;
        end
      end
    end
  end

  AST_LOCK_NEEDS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(mf_ok) && $past(mf_last) && $past(in_valid)); // R3
  AST_MISS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    misses < MISS_W'(LOSS_MF)); // R7
endmodule

// File: rtl/mfa_align_rx.sv
module mfa_align_rx
  import mfa_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 789,
  parameter int unsigned CONFIRM_MF = 2,
  parameter int unsigned LOSS_MF = 3,
  localparam int unsigned POS_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic [POS_W-1:0] bit_pos,
  output logic [1:0]       frame_num,
  output logic             in_sync,
  output logic             link_valid,
  output logic             link_bit,
  output logic             alarm
);
  logic align_slot, align_exp, link_slot, alarm_slot;
  logic mismatch, slip, mf_last;

  mfa_pos_counter #(.FRAME_LEN(FRAME_LEN), .POS_W(POS_W), .FRM_W(FRM_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .adv(in_valid && !slip),
    .bit_pos(bit_pos), .frame_num(frame_num), .mf_last(mf_last)
  );

  mfa_slot_decode #(.FRAME_LEN(FRAME_LEN), .POS_W(POS_W)) u_dec (
    .bit_pos(bit_pos), .frame_num(frame_num),
    .align_slot(align_slot), .align_exp(align_exp),
    .link_slot(link_slot), .alarm_slot(alarm_slot)
  );

  assign mismatch = align_slot && (in_bit != align_exp);

  mfa_sync_ctrl #(.CONFIRM_MF(CONFIRM_MF), .LOSS_MF(LOSS_MF)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mismatch(mismatch),
    .mf_last(mf_last), .locked(in_sync), .slip(slip)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_valid <= 1'b0;
      link_bit   <= 1'b0;
      alarm      <= 1'b0;
    end else begin
      link_valid <= in_valid && in_sync && link_slot;
      if (in_valid && in_sync && link_slot) link_bit <= in_bit;
      if (in_valid && in_sync && alarm_slot) alarm <= in_bit;
    end
  end

  AST_SYNC_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> bit_pos == '0 && frame_num == 2'd0); // R3
  AST_LOSS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sync) |-> bit_pos == '0 && frame_num == 2'd0); // R7
  AST_LINK_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |-> $past(in_sync)); // R9
  AST_ALARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sync |=> $stable(alarm)); // R6
  AST_NO_SLIP_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync && in_valid && !$past(in_valid) |=> $changed(bit_pos) || $changed(frame_num)); // R8
endmodule

// File: tb/sim_mfa_align_rx.sv
`timescale 1ns/1ps
module sim_mfa_align_rx;
  localparam int L = 24;
  localparam int PW = $clog2(L);

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic [PW-1:0] bit_pos;
  logic [1:0] frame_num;
  logic in_sync, link_valid, link_bit, alarm;

  int checks = 0, fails = 0, cyc = 0;
  int tx_f, tx_p;
  bit held_alarm = 1'b0, mf_alarm = 1'b0, corrupt = 1'b0;

  mfa_align_rx #(.FRAME_LEN(L)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .bit_pos(bit_pos), .frame_num(frame_num), .in_sync(in_sync),
    .link_valid(link_valid), .link_bit(link_bit), .alarm(alarm)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // -1: not an alignment bit; else expected value (0-based bit index p)
  function automatic int align_val(int f, int p);
    if (f == 0 && p >= L-5 && p <= L-2) return (p <= L-4) ? 1 : 0;
    if (f == 1 && p >= L-5) return (p == L-5 || p == L-3) ? 1 : 0;
    return -1;
  endfunction
  function automatic bit is_link(int f, int p);
    return (f == 0 || f == 2) && p == L-1;
  endfunction
  function automatic bit is_alarm(int f, int p);
    return f == 2 && p == L-2;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(bit v, bit b);
    @(negedge clk);
    in_valid = v;
    in_bit = b;
    @(posedge clk);
    #2;
  endtask

  task automatic tx_one();
    bit b, was;
    int av;
    if ($urandom % 5 == 0) drive(1'b0, 1'($urandom));
    av = align_val(tx_f, tx_p);
    if (tx_f == 0 && tx_p == 0) mf_alarm = 1'($urandom);
    if (av >= 0) b = 1'(av);
    else if (is_alarm(tx_f, tx_p)) b = mf_alarm;
    else if (tx_f == 2 && tx_p >= L-5) b = 1'b1;
    else b = 1'($urandom);
    if (corrupt && tx_f == 1 && tx_p == L-3) b = ~b;
    was = in_sync;
    drive(1'b1, b);
    if (was && is_link(tx_f, tx_p))
      check(link_valid && link_bit == b, "R5 link", {link_valid, link_bit}, {1'b1, b});
    if (!was)
      check(!link_valid, "R9 link quiet", link_valid, 0);
    if (is_alarm(tx_f, tx_p)) begin
      if (was) held_alarm = b;
      check(alarm == held_alarm, was ? "R6 alarm load" : "R6 alarm hold", alarm, held_alarm);
    end
    tx_p++;
    if (tx_p == L) begin tx_p = 0; tx_f = (tx_f + 1) % 4; end
    if (was && in_sync)
      check(bit_pos == PW'(tx_p) && frame_num == 2'(tx_f), "R4 position",
            frame_num * 1000 + bit_pos, tx_f * 1000 + tx_p);
  endtask

  task automatic run_mfs(int n);
    for (int i = 0; i < n * 4 * L; i++) tx_one();
  endtask

  initial begin
    int steps;
    void'($urandom(32'd4021));
    repeat (3) @(posedge clk);
    #2;
    check(!in_sync && !alarm && !link_valid && !link_bit && bit_pos == 0 && frame_num == 0,
          "R1 reset", {in_sync, alarm, link_valid, link_bit}, 0);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 7; i++) drive(1'b0, 1'($urandom));
    check(bit_pos == 0 && frame_num == 0, "R2 idle", bit_pos, 0);

    tx_f = $urandom % 4;
    tx_p = 1 + $urandom % (L - 1);
    steps = 0;
    while (!in_sync && steps < 40000) begin tx_one(); steps++; end
    check(in_sync, "R8 lock from offset", in_sync, 1);
    check(tx_f == 0 && tx_p == 0, "R3 lock at multiframe end", tx_f * 1000 + tx_p, 0);
    check(bit_pos == PW'(tx_p) && frame_num == 2'(tx_f), "R8 phase",
          frame_num * 1000 + bit_pos, tx_f * 1000 + tx_p);

    run_mfs(4);
    check(in_sync, "R7 clean keeps sync", in_sync, 1);

    corrupt = 1'b1; run_mfs(2); corrupt = 1'b0;
    check(in_sync, "R7 two errored", in_sync, 1);
    run_mfs(1);
    check(in_sync, "R7 clean resets misses", in_sync, 1);

    corrupt = 1'b1; run_mfs(2);
    check(in_sync, "R7 still two", in_sync, 1);
    run_mfs(1); corrupt = 1'b0;
    check(!in_sync, "R7 third errored drops", in_sync, 0);
    check(bit_pos == 0 && frame_num == 0, "R7 drop at boundary", bit_pos, 0);

    run_mfs(1);
    check(!in_sync, "R3 one clean not enough", in_sync, 0);
    run_mfs(1);
    check(in_sync, "R3 two clean relock", in_sync, 1);
    run_mfs(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule